// File: doc/BRIEF.md
# Gain Code Latch and Decoder

This block holds and decodes the gain selection for a programmable gain stage that steps in powers of two. It takes a 3-bit gain code, a range-enable bit and two interchangeable hold inputs. While neither hold input is asserted, the decoded selection follows the inputs on the next clock edge. When either hold input goes high, the code and the range-enable bit present at that edge are kept until both hold inputs are low again.

The decoded result drives a one-hot tap select for the ×1, ×2, ×4, ×8 and ×16 taps of each stage. It also drives a compensation-cut flag for each stage, which is raised when that stage sits at ×8 or ×16. With the cascade strap set, one 3-bit overall code is split across two stages to reach ×1 to ×128. The first stage takes the largest power of two up to ×16 and the second stage takes the rest. Without the strap, the second stage stays at unity. In single-stage mode, codes above 4 fall back to unity and raise an invalid-code flag.

The hold logic is a two-state machine. OPEN follows the inputs. HELD keeps the captured value. The transition CAPTURE (OPEN to HELD) is taken on any edge where a hold input is high, and the inputs at that edge are stored. RELEASE (HELD to OPEN) is taken on the first edge where both hold inputs are low, and the inputs at that edge are loaded. FOLLOW (OPEN to OPEN) and KEEP (HELD to HELD) cover the remaining cases.

Top module: `gain_code_latch`

## Requirements
- R1: While hold_a and hold_b are both low, the tap outputs reflect gain_code, range_on and cascade_mode sampled at the preceding rising clock edge.
- R2: From the edge where either hold input is first seen high, the tap outputs keep the captured code and range_on value while that hold stays high; changes on gain_code and range_on have no effect.
- R3: hold_a and hold_b are interchangeable and are combined by OR: either one alone holds, and the state stays held while at least one of them is high.
- R4: With range_on high in single-stage mode, codes 0 to 4 set the s1_tap bit whose index equals the code (bit 0 = ×1, bit 4 = ×16), and s2_tap = 5'b00001.
- R5: With range_on low, s1_tap and s2_tap are both 5'b00001 and code_bad is low, whatever the code.
- R6: A stage's comp_cut output is high exactly when that stage's tap index is 3 or 4 (×8 or ×16).
- R7: In single-stage mode with range_on high, codes 5, 6 and 7 give unity on both stages and set code_bad high.
- R8: s1_tap and s2_tap each have exactly one bit set at all times. During and after reset both are 5'b00001 and code_bad is low.
- R9: With cascade_mode high and range_on high, code c gives a stage-1 index of min(c,4) and a stage-2 index of c − min(c,4), so the total gain is 2^c. code_bad stays low.
- R10: On the first edge where both hold inputs are low after a hold, the inputs present at that edge are loaded.
- R11: At a 5 ns clock, the capture obeys these timing windows: the code is stable for 6 cycles before the capture edge and for 6 cycles after it; range_on is stable for 8 cycles before and 2 cycles after; successive captures are at least 10 cycles apart. A capture made at exactly these limits stores the correct code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gain_code | input | 3 | Gain code (overall code in cascade mode) |
| range_on | input | 1 | High: honour the code; low: force unity |
| hold_a | input | 1 | Hold input, high holds |
| hold_b | input | 1 | Hold input, equivalent to hold_a |
| cascade_mode | input | 1 | Static strap: split the code over two stages |
| s1_tap | output | 5 | One-hot tap select, stage 1 |
| s1_comp_cut | output | 1 | Compensation cut, stage 1 |
| s2_tap | output | 5 | One-hot tap select, stage 2 |
| s2_comp_cut | output | 1 | Compensation cut, stage 2 |
| code_bad | output | 1 | Out-of-range code seen in single-stage mode |

## Verification
A release of the hold and a new code can land on the same clock edge. The bench drops the hold input and changes gain_code at the same falling edge, and expects the new code one cycle later, because RELEASE loads at that edge. The override and the invalid-code rule also meet in one cycle: range_on low with a code above 4 must give unity with code_bad low. A table row drives exactly that case. The timing windows are checked at their exact limits to show that the capture edge stores the settled code.

// File: rtl/gcl_pkg.sv
package gcl_pkg;
    localparam int CODE_W   = 3;
    localparam int NUM_TAPS = 5;
    localparam int IDX_W    = $clog2(NUM_TAPS);
    localparam int COMP_IDX = 3;

    typedef enum logic {
        ST_OPEN,
        ST_HELD
    } hold_state_t;
endpackage

// File: rtl/gcl_hold_fsm.sv
module gcl_hold_fsm #(
    parameter int CODE_W = gcl_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_a,
    input  logic              hold_b,
    input  logic [CODE_W-1:0] code_in,
    input  logic              range_in,
    output logic [CODE_W-1:0] code_q,
    output logic              range_q
);
    import gcl_pkg::*;

    hold_state_t state, nxt;
    logic        hold_any;
    logic        load;

    assign hold_any = hold_a | hold_b;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OPEN: nxt = hold_any ? ST_HELD : ST_OPEN;   // CAPTURE / FOLLOW
            ST_HELD: nxt = hold_any ? ST_HELD : ST_OPEN;   // KEEP / RELEASE
        endcase
    end

    // the capture edge itself still loads; only HELD with a hold high keeps
    assign load = (state == ST_OPEN) || !hold_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            range_q <= 1'b0;
        end else if (load) begin
            code_q  <= code_in;
            range_q <= range_in;
        end
    end
endmodule

// File: rtl/gcl_split.sv
module gcl_split #(
    parameter int CODE_W   = gcl_pkg::CODE_W,
    parameter int NUM_TAPS = gcl_pkg::NUM_TAPS,
    parameter int IDX_W    = gcl_pkg::IDX_W
) (
    input  logic [CODE_W-1:0] code_q,
    input  logic              range_q,
    input  logic              cascade,
    output logic [IDX_W-1:0]  idx1,
    output logic [IDX_W-1:0]  idx2,
    output logic              bad
);
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(NUM_TAPS - 1);

    always_comb begin
        idx1 = '0;
        idx2 = '0;
        bad  = 1'b0;
        if (range_q) begin
            if (cascade) begin
                if (code_q > MAX_CODE) begin
                    idx1 = IDX_W'(MAX_CODE);
                    idx2 = IDX_W'(code_q - MAX_CODE);
                end else begin
                    idx1 = IDX_W'(code_q);
                end
            end else if (code_q > MAX_CODE) begin
                bad = 1'b1;
            end else begin
                idx1 = IDX_W'(code_q);
            end
        end
    end
endmodule

// File: rtl/gcl_tap_decode.sv
module gcl_tap_decode #(
    parameter int NUM_TAPS = gcl_pkg::NUM_TAPS,
    parameter int IDX_W    = gcl_pkg::IDX_W,
    parameter int COMP_IDX = gcl_pkg::COMP_IDX
) (
    input  logic [IDX_W-1:0]    idx,
    output logic [NUM_TAPS-1:0] tap,
    output logic                comp_cut
);
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign tap[i] = (idx == IDX_W'(i));
    end
    assign comp_cut = (idx >= IDX_W'(COMP_IDX));
endmodule

// File: rtl/gain_code_latch.sv
module gain_code_latch #(
    parameter int CODE_W   = gcl_pkg::CODE_W,
    parameter int NUM_TAPS = gcl_pkg::NUM_TAPS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   gain_code,
    input  logic                range_on,
    input  logic                hold_a,
    input  logic                hold_b,
    input  logic                cascade_mode,
    output logic [NUM_TAPS-1:0] s1_tap,
    output logic                s1_comp_cut,
    output logic [NUM_TAPS-1:0] s2_tap,
    output logic                s2_comp_cut,
    output logic                code_bad
);
    localparam int IDX_W  = $clog2(NUM_TAPS);
    localparam int STAGES = 2;

    logic [CODE_W-1:0]   code_q;
    logic                range_q;
    logic [IDX_W-1:0]    idx   [STAGES];
    logic [NUM_TAPS-1:0] taps  [STAGES];
    logic                cuts  [STAGES];

    gcl_hold_fsm #(.CODE_W(CODE_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_a   (hold_a),
        .hold_b   (hold_b),
        .code_in  (gain_code),
        .range_in (range_on),
        .code_q   (code_q),
        .range_q  (range_q)
    );

    gcl_split #(.CODE_W(CODE_W), .NUM_TAPS(NUM_TAPS), .IDX_W(IDX_W)) u_split (
        .code_q  (code_q),
        .range_q (range_q),
        .cascade (cascade_mode),
        .idx1    (idx[0]),
        .idx2    (idx[1]),
        .bad     (code_bad)
    );

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        gcl_tap_decode #(.NUM_TAPS(NUM_TAPS), .IDX_W(IDX_W)) u_dec (
            .idx      (idx[s]),
            .tap      (taps[s]),
            .comp_cut (cuts[s])
        );
    end

    assign s1_tap      = taps[0];
    assign s2_tap      = taps[1];
    assign s1_comp_cut = cuts[0];
    assign s2_comp_cut = cuts[1];
endmodule

// File: rtl/gain_code_latch_chk.sv
module gain_code_latch_chk #(
    parameter int CODE_W         = 3,
    parameter int NUM_TAPS       = 5,
    parameter int COMP_IDX       = 3,
    parameter int CLK_NS         = 5,
    parameter int CODE_SETUP_NS  = 30,
    parameter int CODE_HOLD_NS   = 30,
    parameter int RANGE_SETUP_NS = 40,
    parameter int RANGE_HOLD_NS  = 10,
    parameter int MIN_PERIOD_NS  = 50
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CODE_W-1:0]   gain_code,
    input logic                range_on,
    input logic                hold_a,
    input logic                hold_b,
    input logic                cascade_mode,
    input logic [NUM_TAPS-1:0] s1_tap,
    input logic                s1_comp_cut,
    input logic [NUM_TAPS-1:0] s2_tap,
    input logic                code_bad
);
    localparam int C_SU  = (CODE_SETUP_NS  + CLK_NS - 1) / CLK_NS;
    localparam int C_HD  = (CODE_HOLD_NS   + CLK_NS - 1) / CLK_NS;
    localparam int R_SU  = (RANGE_SETUP_NS + CLK_NS - 1) / CLK_NS;
    localparam int R_HD  = (RANGE_HOLD_NS  + CLK_NS - 1) / CLK_NS;
    localparam int T_MIN = (MIN_PERIOD_NS  + CLK_NS - 1) / CLK_NS;
    localparam logic [7:0] SAT = 8'hFF;

    logic              hold_any, hold_prev, rise;
    logic [CODE_W-1:0] code_prev;
    logic              range_prev;
    logic [7:0]        code_age, range_age, since_rise;

    assign hold_any = hold_a | hold_b;
    assign rise     = hold_any && !hold_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_prev  <= 1'b0;
            code_prev  <= '0;
            range_prev <= 1'b0;
            code_age   <= SAT;
            range_age  <= SAT;
            since_rise <= SAT;
        end else begin
            hold_prev  <= hold_any;
            code_prev  <= gain_code;
            range_prev <= range_on;
            code_age   <= (gain_code != code_prev) ? 8'd0 : ((code_age == SAT) ? SAT : code_age + 8'd1);
            range_age  <= (range_on != range_prev) ? 8'd0 : ((range_age == SAT) ? SAT : range_age + 8'd1);
            since_rise <= rise ? 8'd0 : ((since_rise == SAT) ? SAT : since_rise + 8'd1);
        end
    end

    assert_tap_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(s1_tap) && $onehot(s2_tap));
    assert_comp_matches_tap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s1_comp_cut == (|s1_tap[NUM_TAPS-1:COMP_IDX]));
    assert_held_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_any && hold_prev) |=> $stable(s1_tap) && $stable(s2_tap));
    assert_force_unity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!range_on && !hold_any) |=> (s1_tap == 1) && (s2_tap == 1) && !code_bad);
    assert_bad_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cascade_mode && range_on && !hold_any && (gain_code > 3'd4)) |=>
        cascade_mode || (code_bad && (s1_tap == 1)));
    assert_code_setup_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (code_age >= 8'(C_SU)));
    assert_range_setup_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (range_age >= 8'(R_SU)));
    assert_min_period_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (since_rise >= 8'(T_MIN)));
    assert_code_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rise < 8'(C_HD)) |-> (gain_code == code_prev));
    assert_range_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rise < 8'(R_HD)) |-> (range_on == range_prev));
endmodule

bind gain_code_latch gain_code_latch_chk #(.CODE_W(CODE_W), .NUM_TAPS(NUM_TAPS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gain_code    (gain_code),
    .range_on     (range_on),
    .hold_a       (hold_a),
    .hold_b       (hold_b),
    .cascade_mode (cascade_mode),
    .s1_tap       (s1_tap),
    .s1_comp_cut  (s1_comp_cut),
    .s2_tap       (s2_tap),
    .code_bad     (code_bad)
);

// File: tb/gain_code_latch_tb.sv
module gain_code_latch_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] gain_code = '0;
    logic       range_on = 1'b0;
    logic       hold_a = 1'b0;
    logic       hold_b = 1'b0;
    logic       cascade_mode = 1'b0;
    logic [4:0] s1_tap, s2_tap;
    logic       s1_comp_cut, s2_comp_cut, code_bad;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    gain_code_latch u_dut (
        .clk(clk), .rst_n(rst_n), .gain_code(gain_code), .range_on(range_on),
        .hold_a(hold_a), .hold_b(hold_b), .cascade_mode(cascade_mode),
        .s1_tap(s1_tap), .s1_comp_cut(s1_comp_cut), .s2_tap(s2_tap),
        .s2_comp_cut(s2_comp_cut), .code_bad(code_bad)
    );

    // {cascade, range, code[3], s1[5], s2[5], cut1, cut2, bad}
    localparam logic [17:0] VEC [19] = '{
        {1'b0,1'b1,3'd0,5'b00001,5'b00001,1'b0,1'b0,1'b0},
        {1'b0,1'b1,3'd1,5'b00010,5'b00001,1'b0,1'b0,1'b0},
        {1'b0,1'b1,3'd2,5'b00100,5'b00001,1'b0,1'b0,1'b0},
        {1'b0,1'b1,3'd3,5'b01000,5'b00001,1'b1,1'b0,1'b0},
        {1'b0,1'b1,3'd4,5'b10000,5'b00001,1'b1,1'b0,1'b0},
        {1'b0,1'b1,3'd5,5'b00001,5'b00001,1'b0,1'b0,1'b1},
        {1'b0,1'b1,3'd6,5'b00001,5'b00001,1'b0,1'b0,1'b1},
        {1'b0,1'b1,3'd7,5'b00001,5'b00001,1'b0,1'b0,1'b1},
        {1'b0,1'b0,3'd3,5'b00001,5'b00001,1'b0,1'b0,1'b0},
        {1'b0,1'b0,3'd6,5'b00001,5'b00001,1'b0,1'b0,1'b0},
        {1'b1,1'b1,3'd0,5'b00001,5'b00001,1'b0,1'b0,1'b0},
        {1'b1,1'b1,3'd1,5'b00010,5'b00001,1'b0,1'b0,1'b0},
        {1'b1,1'b1,3'd2,5'b00100,5'b00001,1'b0,1'b0,1'b0},
        {1'b1,1'b1,3'd3,5'b01000,5'b00001,1'b1,1'b0,1'b0},
        {1'b1,1'b1,3'd4,5'b10000,5'b00001,1'b1,1'b0,1'b0},
        {1'b1,1'b1,3'd5,5'b10000,5'b00010,1'b1,1'b0,1'b0},
        {1'b1,1'b1,3'd6,5'b10000,5'b00100,1'b1,1'b0,1'b0},
        {1'b1,1'b1,3'd7,5'b10000,5'b01000,1'b1,1'b1,1'b0},
        {1'b1,1'b0,3'd5,5'b00001,5'b00001,1'b0,1'b0,1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [12:0] outs();
        return {s1_tap, s2_tap, s1_comp_cut, s2_comp_cut, code_bad};
    endfunction

    initial begin
        cyc(2);
        check("R8 reset", outs(), {5'b00001, 5'b00001, 3'b000});
        rst_n = 1'b1;
        cyc(1);
        check("R8 after reset", outs(), {5'b00001, 5'b00001, 3'b000});

        // table: transparent decode (R1, R4, R5, R6, R7, R9)
        for (int i = 0; i < 19; i++) begin
            string tag;
            cascade_mode = VEC[i][17];
            range_on     = VEC[i][16];
            gain_code    = VEC[i][15:13];
            cyc(1);
            if (VEC[i][17])        tag = "R9 R6 R1";
            else if (!VEC[i][16])  tag = "R5 R1";
            else if (VEC[i][15:13] > 3'd4) tag = "R7 R1";
            else                   tag = "R4 R6 R1";
            check(tag, outs(), VEC[i][12:0]);
        end

        // hold with hold_a (R2, R10)
        cascade_mode = 1'b0; range_on = 1'b1; gain_code = 3'd2;
        cyc(12);
        check("R1 follow", s1_tap, 5'b00100);
        hold_a = 1'b1;
        cyc(9);
        gain_code = 3'd4;
        cyc(2);
        check("R2 code ignored", s1_tap, 5'b00100);
        range_on = 1'b0;
        cyc(2);
        check("R2 range ignored", s1_tap, 5'b00100);
        hold_a = 1'b0;
        cyc(1);
        check("R10 release loads", s1_tap, 5'b00001);
        range_on = 1'b1;
        cyc(1);
        check("R10 follows again", {s1_tap, s1_comp_cut}, {5'b10000, 1'b1});

        // hold with hold_b, then OR of both (R3)
        cyc(12);
        hold_b = 1'b1;
        cyc(9);
        gain_code = 3'd1;
        cyc(2);
        check("R3 hold_b alone", s1_tap, 5'b10000);
        hold_a = 1'b1;
        cyc(1);
        hold_b = 1'b0;
        cyc(2);
        check("R3 hold_a keeps", s1_tap, 5'b10000);
        // release and new code on the same edge
        hold_a = 1'b0;
        gain_code = 3'd2;
        cyc(1);
        check("R10 release with new code", s1_tap, 5'b00100);

        // capture at the timing limits (R11)
        cyc(12);
        gain_code = 3'd3;
        cyc(7);
        hold_a = 1'b1;
        cyc(7);
        gain_code = 3'd0;
        cyc(1);
        check("R11 capture at limit", {s1_tap, s1_comp_cut}, {5'b01000, 1'b1});
        hold_a = 1'b0;
        cyc(1);
        check("R10 release to code 0", s1_tap, 5'b00001);

        // reset while held (R8)
        gain_code = 3'd4;
        cyc(12);
        hold_b = 1'b1;
        cyc(3);
        rst_n = 1'b0;
        cyc(1);
        check("R8 reset mid hold", outs(), {5'b00001, 5'b00001, 3'b000});

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule